// File: doc/BRIEF.md
# Windowed watchdog countdown core

This block is the counting heart of a watchdog timer that lives in a slow timer clock domain. An 8-bit divide value sets how many clock cycles make up one count tick. A 16-bit counter starts from a reload value and steps down by one on each tick. Software must refresh the counter with a feed strobe before it runs out. If the counter is allowed to run out, the block raises a reset request.

The core can also act as a window watchdog. A feed is only accepted once the count has fallen to or below a programmed window value. A feed that arrives earlier is treated as a fault and raises a reset at once. An optional early interrupt warns software ahead of expiry. It is raised when a tick brings the count to one less than a programmed threshold, and it stays set until software clears it.

Counting stops automatically while a debug halt is active. During sleep, counting also stops unless the low-power run bit is set. The surrounding register interface and the clock-domain crossing are not part of this core. Its configuration arrives as plain input values.

Top module: `wdg_window_core`

## Requirements
- R1: While rstN is low, count reads 0xFFFF (parameter RST_LOAD), and earlyIrq and resetReq are 0.
- R2: While enable is 0, count follows reloadVal one cycle later. earlyIrq and resetReq stay 0, and a feed has no effect.
- R3: While running, count decreases by one every divVal+1 clock cycles. The first decrement comes on the (divVal+1)-th clock edge after enable is sampled high.
- R4: A tick taken while count is 0 is a timeout. It raises resetReq for exactly one cycle, and count reloads from reloadVal on the same edge.
- R5: A feed while count is at or below window reloads count and raises no reset. It also restarts the divider, so the next decrement comes divVal+1 edges after the feed edge.
- R6: A feed while count is strictly above window raises resetReq for one cycle and reloads count. A window of 0xFFFF therefore never trips.
- R7: With earlyIntEn set, a tick that moves count from earlyThresh to earlyThresh-1 sets earlyIrq. The flag stays set until it is cleared. A threshold of 0 never fires.
- R8: A high earlyIntClr clears earlyIrq on the next edge. If a new set event comes in the same cycle, the set takes priority.
- R9: While debugHalt is 1, count and the divider hold their values.
- R10: While sleep is 1 and lowPowerRun is 0, counting freezes. With lowPowerRun set, counting continues, and both the timeout and the early interrupt still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog running enable |
| feed | input | 1 | Refresh strobe, one cycle |
| debugHalt | input | 1 | Processor halted in debug; freezes counting |
| sleep | input | 1 | System in sleep mode |
| lowPowerRun | input | 1 | Keep counting during sleep |
| divVal | input | 8 | Divide value; tick period is divVal+1 cycles |
| reloadVal | input | 16 | Value loaded on feed, timeout or while disabled |
| window | input | 16 | Feed is a fault while count is above this value |
| earlyThresh | input | 16 | Early interrupt fires when count reaches this minus one |
| earlyIntEn | input | 1 | Early interrupt enable |
| earlyIntClr | input | 1 | Clear the sticky early interrupt |
| earlyIrq | output | 1 | Sticky early interrupt |
| resetReq | output | 1 | One-cycle reset request |
| count | output | 16 | Current counter value |

## Verification
The bench probes the window edge from both sides. A feed with the count equal to the window must pass, and a feed one count above it must trip. A design that used the wrong comparison would reset on a legal feed or miss an early one. The bench measures the exact cycle of the first decrement after a feed. A divider that failed to restart would show up as an early tick. The timeout cycle is checked to land on a tick taken at zero, with the reload happening on the same edge. The early interrupt is checked for the minus-one offset, for staying set, for being cleared, and for staying quiet when the count is only loaded rather than ticked onto the threshold. The bench also checks that debug halt and plain sleep truly freeze the count, while sleep with low-power run keeps the count moving and still times out.

// File: rtl/wdg_core_pkg.sv
package wdg_core_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic preClr;
    logic setIrq;
    logic clrIrq;
    logic fireRst;
  } wdgStrobe_t;

  // compare results from datapath back to control
  typedef struct packed {
    logic isZero;
    logic aboveWin;
    logic atThresh;
  } wdgFlags_t;

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] divVal,
  output logic             tick
);

  logic [PRE_W-1:0] preCnt;

  // tick on the last cycle of each divVal+1 cycle period
  assign tick = run && (preCnt >= divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (clr) begin
      preCnt <= '0;
    end else if (run) begin
      if (tick) preCnt <= '0;
      else      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_core_pkg::*;
(
  input  logic       enable,
  input  logic       feed,
  input  logic       debugHalt,
  input  logic       sleep,
  input  logic       lowPowerRun,
  input  logic       earlyIntEn,
  input  logic       earlyIntClr,
  input  logic       tick,
  input  wdgFlags_t  flags,
  output logic       run,
  output wdgStrobe_t strb
);

  logic sleepGate;

  assign sleepGate = sleep && !lowPowerRun;
  assign run       = enable && !debugHalt && !sleepGate;

  always_comb begin
    strb        = '0;
    strb.clrIrq = earlyIntClr;
    if (!enable) begin
      // idle: track reload, drop the interrupt, keep divider at zero
      strb.loadCnt = 1'b1;
      strb.preClr  = 1'b1;
      strb.clrIrq  = 1'b1;
    end else if (feed) begin
      // feed wins over a tick in the same cycle
      strb.loadCnt = 1'b1;
      strb.preClr  = 1'b1;
      strb.fireRst = flags.aboveWin;
    end else if (tick) begin
      if (flags.isZero) begin
        strb.loadCnt = 1'b1;
        strb.fireRst = 1'b1;
      end else begin
        strb.decCnt = 1'b1;
        strb.setIrq = earlyIntEn && flags.atThresh;
      end
    end
  end

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_core_pkg::*;
#(
  parameter int              CNT_W    = 16,
  parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strb,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] window,
  input  logic [CNT_W-1:0] earlyThresh,
  output wdgFlags_t        flags,
  output logic [CNT_W-1:0] count,
  output logic             earlyIrq,
  output logic             resetReq
);

  assign flags.isZero   = (count == '0);
  assign flags.aboveWin = (count > window);
  assign flags.atThresh = (count == earlyThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= RST_LOAD;
    end else if (strb.loadCnt) begin
      count <= reloadVal;
    end else if (strb.decCnt) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyIrq <= 1'b0;
    end else if (strb.setIrq) begin
      earlyIrq <= 1'b1;
    end else if (strb.clrIrq) begin
      earlyIrq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= strb.fireRst;
  end

endmodule

// File: rtl/wdg_window_core.sv
module wdg_window_core
  import wdg_core_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter int               PRE_W    = 8,
  parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             feed,
  input  logic             debugHalt,
  input  logic             sleep,
  input  logic             lowPowerRun,
  input  logic [PRE_W-1:0] divVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] window,
  input  logic [CNT_W-1:0] earlyThresh,
  input  logic             earlyIntEn,
  input  logic             earlyIntClr,
  output logic             earlyIrq,
  output logic             resetReq,
  output logic [CNT_W-1:0] count
);

  wdgStrobe_t strb;
  wdgFlags_t  flags;
  logic       run;
  logic       tick;

  wdg_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .clr    (strb.preClr),
    .divVal (divVal),
    .tick   (tick)
  );

  wdg_ctrl u_ctrl (
    .enable      (enable),
    .feed        (feed),
    .debugHalt   (debugHalt),
    .sleep       (sleep),
    .lowPowerRun (lowPowerRun),
    .earlyIntEn  (earlyIntEn),
    .earlyIntClr (earlyIntClr),
    .tick        (tick),
    .flags       (flags),
    .run         (run),
    .strb        (strb)
  );

  wdg_datapath #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reloadVal   (reloadVal),
    .window      (window),
    .earlyThresh (earlyThresh),
    .flags       (flags),
    .count       (count),
    .earlyIrq    (earlyIrq),
    .resetReq    (resetReq)
  );

endmodule

// File: rtl/wdg_window_core_chk.sv
module wdg_window_core_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             feed,
  input logic             debugHalt,
  input logic             sleep,
  input logic             lowPowerRun,
  input logic [PRE_W-1:0] divVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] window,
  input logic [CNT_W-1:0] earlyThresh,
  input logic             earlyIntEn,
  input logic             earlyIntClr,
  input logic             earlyIrq,
  input logic             resetReq,
  input logic [CNT_W-1:0] count
);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!earlyIrq && !resetReq));

  // R4 R6
  rst_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (count == $past(reloadVal)));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyIrq) |-> ($past(earlyIntEn) && (count == CNT_W'($past(earlyThresh) - 1'b1))));

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(earlyIrq) |-> ($past(earlyIntClr) || !$past(enable)));

  // R9
  debug_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && debugHalt && !feed) |=> $stable(count));

  // R10
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sleep && !lowPowerRun && !feed) |=> $stable(count));

endmodule

bind wdg_window_core wdg_window_core_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .feed        (feed),
  .debugHalt   (debugHalt),
  .sleep       (sleep),
  .lowPowerRun (lowPowerRun),
  .divVal      (divVal),
  .reloadVal   (reloadVal),
  .window      (window),
  .earlyThresh (earlyThresh),
  .earlyIntEn  (earlyIntEn),
  .earlyIntClr (earlyIntClr),
  .earlyIrq    (earlyIrq),
  .resetReq    (resetReq),
  .count       (count)
);

// File: tb/sim_wdg_window_core.sv
module sim_wdg_window_core;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable, feed, debugHalt, sleep, lowPowerRun;
  logic [7:0]  divVal;
  logic [15:0] reloadVal, window, earlyThresh;
  logic        earlyIntEn, earlyIntClr;
  logic        earlyIrq, resetReq;
  logic [15:0] count;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  wdg_window_core u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .feed(feed),
    .debugHalt(debugHalt), .sleep(sleep), .lowPowerRun(lowPowerRun),
    .divVal(divVal), .reloadVal(reloadVal), .window(window),
    .earlyThresh(earlyThresh), .earlyIntEn(earlyIntEn),
    .earlyIntClr(earlyIntClr), .earlyIrq(earlyIrq),
    .resetReq(resetReq), .count(count)
  );

  typedef struct packed {
    logic [7:0]  div;
    logic [15:0] rld;
    logic [15:0] edgesRun;
    logic [15:0] thr;
    logic        ie;
    logic [15:0] expCnt;
    logic        expIrq;
  } vec_t;

  // R3 R7: run from a fresh enable for edgesRun edges
  localparam vec_t VECS [5] = '{
    '{div: 8'd0, rld: 16'd10,  edgesRun: 16'd3,  thr: 16'd8,  ie: 1'b1, expCnt: 16'd7,  expIrq: 1'b1},
    '{div: 8'd3, rld: 16'd20,  edgesRun: 16'd9,  thr: 16'd10, ie: 1'b1, expCnt: 16'd18, expIrq: 1'b0},
    '{div: 8'd4, rld: 16'd100, edgesRun: 16'd25, thr: 16'd96, ie: 1'b0, expCnt: 16'd95, expIrq: 1'b0},
    '{div: 8'd1, rld: 16'd5,   edgesRun: 16'd11, thr: 16'd1,  ie: 1'b1, expCnt: 16'd0,  expIrq: 1'b1},
    '{div: 8'd2, rld: 16'd50,  edgesRun: 16'd2,  thr: 16'd51, ie: 1'b1, expCnt: 16'd50, expIrq: 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] d, input logic [15:0] r,
                       input logic [15:0] w, input logic [15:0] t, input logic ie);
    enable = 1'b0; feed = 1'b0; debugHalt = 1'b0; sleep = 1'b0;
    lowPowerRun = 1'b0; earlyIntClr = 1'b0;
    divVal = d; reloadVal = r; window = w; earlyThresh = t; earlyIntEn = ie;
    edges(1);
    enable = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; feed = 1'b0; debugHalt = 1'b0; sleep = 1'b0;
    lowPowerRun = 1'b0; divVal = 8'd0; reloadVal = 16'h1234; window = 16'hFFFF;
    earlyThresh = 16'd0; earlyIntEn = 1'b0; earlyIntClr = 1'b0;
    edges(2);
    check("R1", "count in reset", 32'(count), 32'hFFFF);
    check("R1", "irq in reset", 32'(earlyIrq), 0);
    check("R1", "rst in reset", 32'(resetReq), 0);
    rstN = 1'b1;
    edges(1);
    check("R2", "disabled count tracks reload", 32'(count), 32'h1234);
    feed = 1'b1;
    edges(1);
    feed = 1'b0;
    check("R2", "feed while disabled no reset", 32'(resetReq), 0);
    check("R2", "feed while disabled count", 32'(count), 32'h1234);

    for (int i = 0; i < 5; i++) begin
      setup(VECS[i].div, VECS[i].rld, 16'hFFFF, VECS[i].thr, VECS[i].ie);
      edges(int'(VECS[i].edgesRun));
      check("R3", $sformatf("vec%0d count", i), 32'(count), 32'(VECS[i].expCnt));
      check("R7", $sformatf("vec%0d irq", i), 32'(earlyIrq), 32'(VECS[i].expIrq));
      check("R4", $sformatf("vec%0d no reset", i), 32'(resetReq), 0);
    end

    // R4 timeout
    setup(8'd0, 16'd3, 16'hFFFF, 16'd0, 1'b0);
    edges(3);
    check("R4", "at zero", 32'(count), 0);
    check("R4", "no reset yet", 32'(resetReq), 0);
    edges(1);
    check("R4", "timeout reset", 32'(resetReq), 1);
    check("R4", "timeout reload", 32'(count), 3);
    edges(1);
    check("R4", "reset one cycle", 32'(resetReq), 0);
    check("R4", "count resumes", 32'(count), 2);

    // R6 early feed
    setup(8'd0, 16'd10, 16'd5, 16'd0, 1'b0);
    edges(4);
    check("R6", "count above window", 32'(count), 6);
    feed = 1'b1;
    edges(1);
    feed = 1'b0;
    check("R6", "early feed reset", 32'(resetReq), 1);
    check("R6", "early feed reload", 32'(count), 10);
    edges(1);
    check("R6", "reset one cycle", 32'(resetReq), 0);

    // R5 feed exactly at window
    setup(8'd0, 16'd10, 16'd5, 16'd0, 1'b0);
    edges(5);
    check("R5", "count at window", 32'(count), 5);
    feed = 1'b1;
    edges(1);
    feed = 1'b0;
    check("R5", "legal feed no reset", 32'(resetReq), 0);
    check("R5", "legal feed reload", 32'(count), 10);

    // R5 divider restart
    setup(8'd2, 16'd30, 16'hFFFF, 16'd0, 1'b0);
    edges(4);
    check("R3", "one tick after three edges", 32'(count), 29);
    feed = 1'b1;
    edges(1);
    feed = 1'b0;
    check("R5", "feed reload", 32'(count), 30);
    edges(2);
    check("R5", "no early tick after feed", 32'(count), 30);
    edges(1);
    check("R5", "tick full period after feed", 32'(count), 29);

    // R9 debug halt
    setup(8'd0, 16'd10, 16'hFFFF, 16'd0, 1'b0);
    edges(2);
    debugHalt = 1'b1;
    edges(5);
    check("R9", "frozen in debug", 32'(count), 8);
    debugHalt = 1'b0;
    edges(1);
    check("R9", "resumes after debug", 32'(count), 7);

    // R10 sleep gating
    sleep = 1'b1;
    edges(4);
    check("R10", "frozen in sleep", 32'(count), 7);
    lowPowerRun = 1'b1;
    edges(3);
    check("R10", "counts in low-power sleep", 32'(count), 4);
    sleep = 1'b0; lowPowerRun = 1'b0;
    setup(8'd0, 16'd2, 16'hFFFF, 16'd0, 1'b0);
    sleep = 1'b1; lowPowerRun = 1'b1;
    edges(3);
    check("R10", "sleep timeout reset", 32'(resetReq), 1);
    sleep = 1'b0; lowPowerRun = 1'b0;

    // R7 R8 sticky and clear
    setup(8'd0, 16'd20, 16'hFFFF, 16'd15, 1'b1);
    edges(5);
    check("R7", "irq not yet at threshold", 32'(earlyIrq), 0);
    edges(1);
    check("R7", "irq at threshold minus one", 32'(earlyIrq), 1);
    check("R7", "count at fire", 32'(count), 14);
    edges(3);
    check("R7", "irq sticky", 32'(earlyIrq), 1);
    earlyIntClr = 1'b1;
    edges(1);
    earlyIntClr = 1'b0;
    check("R8", "irq cleared", 32'(earlyIrq), 0);
    edges(4);
    check("R8", "irq stays clear", 32'(earlyIrq), 0);

    // R7 threshold zero never fires
    setup(8'd0, 16'd3, 16'hFFFF, 16'd0, 1'b1);
    edges(5);
    check("R7", "threshold zero silent", 32'(earlyIrq), 0);

    // R2 disable drops irq
    setup(8'd0, 16'd5, 16'hFFFF, 16'd4, 1'b1);
    edges(2);
    check("R7", "irq set before disable", 32'(earlyIrq), 1);
    enable = 1'b0;
    edges(1);
    check("R2", "disable clears irq", 32'(earlyIrq), 0);
    check("R2", "disable reloads", 32'(count), 5);

    summary();
    $finish;
  end

endmodule